// File: doc/BRIEF.md
# Multi-Domain Skew Calibration Sequencer

This block holds the delay settings for a row of independently buffered clock domains. Each domain has three settings: a 5-bit calibrated delay value, a signed 3-bit intentional offset and an enable bit. The block drives a 5-bit delay code and an enable to each domain buffer. The code is the calibrated value plus the offset, clamped to 0..31. A chain of pairwise phase detectors sits between neighbouring domains. Detector k reports whether domain k+1's edge arrives later than domain k's edge.

A host starts a calibration pass through a small register interface. Domain 0 is the fixed reference, and the pass handles the detectors in ascending order. For detector k, it nudges domain k+1 one count per sample until the detector's answer flips or the value reaches a limit, and then moves on. Between a step and the sample that follows it, the pass waits a settle time so that the delay line and the detector can respond. A disabled domain keeps its value, and the pass stops before it, so that it and every domain beyond it stay unchanged.

The host port is a plain single-cycle register port with no valid/ready, because it carries only configuration and status. A write takes effect at the clock edge where `host_we` is high. Reads are combinational from `host_addr`, so no back-pressure arises.

Top module: `skew_calib_top`

## Requirements
- R1: After reset, every domain has calibrated value 16, offset 0 and enable 1, and the control register reads done=0 and busy=0.
- R2: A host write to domain address i (0..N_DOM-1) loads the calibrated value from wdata[4:0], the offset from wdata[7:5] (two's complement) and the enable from wdata[8]. A read of that address returns the same fields in the same positions, plus the applied code in [13:9]. Addresses that are neither a domain nor 0xFF read as 0.
- R3: The applied code of each domain equals the calibrated value plus the sign-extended offset, clamped to 0..31. It appears on `dom_code[5i+4:5i]` in the same cycle.
- R4: `dom_en[i]` equals the enable bit of domain i.
- R5: Writing 1 to bit 0 of address 0xFF while idle starts a pass, which clears done and sets busy (read bits [0] and [1] of 0xFF). When the pass ends, busy falls and done rises in the same cycle. A start written while busy is ignored.
- R6: Detectors are handled in ascending order. `pd_late[k]`=1 means domain k+1 is late, so its value is decremented. `pd_late[k]`=0 means its value is incremented. Domain 0's value is never changed by a pass.
- R7: For each detector, stepping stops at the first sample whose answer differs from the first sample's answer, or when the next step would go below 0 or above 31. No two steps occur in adjacent cycles.
- R8: If domain 0 or domain k+1 is disabled when detector k is reached, the pass ends there. Domains k+1 and above keep their values.
- R9: Host writes to domain registers while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Register address |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data |
| pd_late | input | N_DOM-1 | Detector k: 1 when domain k+1 lags domain k |
| dom_code | output | 5*N_DOM | Applied delay code per domain |
| dom_en | output | N_DOM | Buffer enable per domain |

## Verification
The hardest situation to reach is a pass that ends early because a domain in the middle of the chain is disabled, while the domains before it still need real stepping. The bench models the detectors itself, with per-domain intrinsic delays, computing each answer from the `dom_code` outputs. It disturbs the delays of domains on both sides of a disabled domain and then checks that only the near side moved. A very late domain drives its value to the floor, which exercises the limit stop, and writes and a second start issued during a pass test that they are ignored.

// File: rtl/skewcal_pkg.sv
package skewcal_pkg;
  localparam int CODE_W    = 5;
  localparam int OFF_W     = 3;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hFF;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_CHECK,
    WK_WAIT,
    WK_SAMPLE
  } walk_state_e;

  // signed add with saturation to the code range
  function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] base,
                                                 input logic [OFF_W-1:0]  off);
    logic signed [CODE_W+1:0] sum;
    sum = $signed({2'b00, base}) + $signed({{(CODE_W+2-OFF_W){off[OFF_W-1]}}, off});
    if (sum < 0)
      return '0;
    else if (sum > $signed({2'b00, {CODE_W{1'b1}}}))
      return {CODE_W{1'b1}};
    else
      return sum[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/skewcal_regbank.sv
module skewcal_regbank
  import skewcal_pkg::*;
#(
  parameter int N_DOM    = 47,
  parameter int CAL_INIT = 16,
  localparam int IDX_W   = $clog2(N_DOM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [CODE_W-1:0]       wr_cal,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic                    wr_enable,
  input  logic                    step_inc,
  input  logic                    step_dec,
  input  logic [IDX_W-1:0]        step_idx,
  output logic [N_DOM*CODE_W-1:0] cal_flat,
  output logic [N_DOM*OFF_W-1:0]  off_flat,
  output logic [N_DOM-1:0]        en_vec
);
  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    logic [CODE_W-1:0] cal_q;
    logic [OFF_W-1:0]  off_q;
    logic              en_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cal_q <= CODE_W'(CAL_INIT);
        off_q <= '0;
        en_q  <= 1'b1;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        cal_q <= wr_cal;
        off_q <= wr_off;
        en_q  <= wr_enable;
      end else if (step_idx == IDX_W'(i)) begin
        if (step_inc)
          cal_q <= cal_q + CODE_W'(1);
        else if (step_dec)
          cal_q <= cal_q - CODE_W'(1);
      end
    end
    assign cal_flat[i*CODE_W +: CODE_W] = cal_q;
    assign off_flat[i*OFF_W +: OFF_W]   = off_q;
    assign en_vec[i]                    = en_q;
  end
endmodule

// File: rtl/skewcal_apply.sv
module skewcal_apply
  import skewcal_pkg::*;
#(
  parameter int N_DOM = 47
) (
  input  logic [N_DOM*CODE_W-1:0] cal_flat,
  input  logic [N_DOM*OFF_W-1:0]  off_flat,
  output logic [N_DOM*CODE_W-1:0] code_flat
);
  for (genvar i = 0; i < N_DOM; i++) begin : g_sum
    assign code_flat[i*CODE_W +: CODE_W] =
      sat_code(cal_flat[i*CODE_W +: CODE_W], off_flat[i*OFF_W +: OFF_W]);
  end
endmodule

// File: rtl/skewcal_walker.sv
module skewcal_walker
  import skewcal_pkg::*;
#(
  parameter int N_DOM      = 47,
  parameter int SETTLE_CYC = 2,
  localparam int IDX_W     = $clog2(N_DOM),
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_DOM-2:0]        pd_late,
  input  logic [N_DOM-1:0]        en_vec,
  input  logic [N_DOM*CODE_W-1:0] cal_flat,
  output logic                    busy,
  output logic                    done,
  output logic                    step_inc,
  output logic                    step_dec,
  output logic [IDX_W-1:0]        step_idx
);
  localparam logic [IDX_W-1:0] LAST_DET = IDX_W'(N_DOM - 2);

  walk_state_e       state;
  logic [IDX_W-1:0]  det;
  logic [IDX_W-1:0]  up_idx;
  logic              first;
  logic              dir_dec;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] up_cal;
  logic              want_dec;
  logic              at_limit;
  logic              stop;

  assign up_idx   = det + IDX_W'(1);
  assign up_cal   = cal_flat[int'(up_idx)*CODE_W +: CODE_W];
  assign want_dec = first ? pd_late[det] : dir_dec;
  assign at_limit = want_dec ? (up_cal == '0) : (&up_cal);
  assign stop     = (!first && (pd_late[det] != dir_dec)) || at_limit;
  assign busy     = (state != WK_IDLE);
  assign step_idx = up_idx;
  assign step_dec = (state == WK_SAMPLE) && !stop && want_dec;
  assign step_inc = (state == WK_SAMPLE) && !stop && !want_dec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WK_IDLE;
      det     <= '0;
      first   <= 1'b1;
      dir_dec <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        WK_IDLE: begin
          if (start) begin
            done  <= 1'b0;
            det   <= '0;
            first <= 1'b1;
            state <= WK_CHECK;
          end
        end
        WK_CHECK: begin
          if (!en_vec[0] || !en_vec[up_idx]) begin
            done  <= 1'b1;
            state <= WK_IDLE;
          end else begin
            cnt   <= CNT_W'(SETTLE_CYC);
            state <= WK_WAIT;
          end
        end
        WK_WAIT: begin
          if (cnt == '0)
            state <= WK_SAMPLE;
          else
            cnt <= cnt - CNT_W'(1);
        end
        WK_SAMPLE: begin
          dir_dec <= want_dec;
          if (stop) begin
            if (det == LAST_DET) begin
              done  <= 1'b1;
              state <= WK_IDLE;
            end else begin
              det   <= up_idx;
              first <= 1'b1;
              state <= WK_CHECK;
            end
          end else begin
            first <= 1'b0;
            cnt   <= CNT_W'(SETTLE_CYC);
            state <= WK_WAIT;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skew_calib_top.sv
module skew_calib_top
  import skewcal_pkg::*;
#(
  parameter int N_DOM      = 47,
  parameter int SETTLE_CYC = 2,
  parameter int CAL_INIT   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              host_addr,
  input  logic                    host_we,
  input  logic [15:0]             host_wdata,
  output logic [15:0]             host_rdata,
  input  logic [N_DOM-2:0]        pd_late,
  output logic [N_DOM*5-1:0]      dom_code,
  output logic [N_DOM-1:0]        dom_en
);
  localparam int IDX_W = $clog2(N_DOM);

  logic [N_DOM*CODE_W-1:0] cal_flat;
  logic [N_DOM*OFF_W-1:0]  off_flat;
  logic                    busy;
  logic                    done;
  logic                    step_inc;
  logic                    step_dec;
  logic [IDX_W-1:0]        step_idx;
  logic                    is_dom;
  logic                    is_ctrl;
  logic                    dom_wr;
  logic                    start;
  logic [IDX_W-1:0]        sel_idx;

  assign is_dom  = (host_addr < ADDR_W'(N_DOM));
  assign is_ctrl = (host_addr == CTRL_ADDR);
  assign sel_idx = host_addr[IDX_W-1:0];
  assign dom_wr  = host_we && is_dom && !busy;
  assign start   = host_we && is_ctrl && host_wdata[0];

  skewcal_regbank #(.N_DOM(N_DOM), .CAL_INIT(CAL_INIT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (dom_wr),
    .wr_idx   (sel_idx),
    .wr_cal   (host_wdata[4:0]),
    .wr_off   (host_wdata[7:5]),
    .wr_enable(host_wdata[8]),
    .step_inc (step_inc),
    .step_dec (step_dec),
    .step_idx (step_idx),
    .cal_flat (cal_flat),
    .off_flat (off_flat),
    .en_vec   (dom_en)
  );

  skewcal_apply #(.N_DOM(N_DOM)) u_apply (
    .cal_flat (cal_flat),
    .off_flat (off_flat),
    .code_flat(dom_code)
  );

  skewcal_walker #(.N_DOM(N_DOM), .SETTLE_CYC(SETTLE_CYC)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pd_late (pd_late),
    .en_vec  (dom_en),
    .cal_flat(cal_flat),
    .busy    (busy),
    .done    (done),
    .step_inc(step_inc),
    .step_dec(step_dec),
    .step_idx(step_idx)
  );

  always_comb begin
    host_rdata = '0;
    if (is_dom) begin
      host_rdata[4:0]  = cal_flat[int'(sel_idx)*CODE_W +: CODE_W];
      host_rdata[7:5]  = off_flat[int'(sel_idx)*OFF_W +: OFF_W];
      host_rdata[8]    = dom_en[sel_idx];
      host_rdata[13:9] = dom_code[int'(sel_idx)*CODE_W +: CODE_W];
    end else if (is_ctrl) begin
      host_rdata[0] = done;
      host_rdata[1] = busy;
    end
  end
endmodule

// File: rtl/skewcal_chk.sv
module skewcal_chk #(
  parameter int N_DOM = 47,
  localparam int IDX_W = $clog2(N_DOM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               step_inc,
  input logic               step_dec,
  input logic [IDX_W-1:0]   step_idx,
  input logic [N_DOM-1:0]   dom_en,
  input logic [N_DOM*5-1:0] dom_code
);
  a_r5_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_reference_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dom_code[4:0]));

  a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_inc, step_dec}));

  a_r7_steps_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (step_inc || step_dec) |=> !(step_inc || step_dec));

  a_r8_step_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (step_inc || step_dec) |-> (dom_en[step_idx] && dom_en[0]));

  a_r9_enables_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(dom_en));
endmodule

bind skew_calib_top skewcal_chk #(.N_DOM(N_DOM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .step_inc(step_inc),
  .step_dec(step_dec),
  .step_idx(step_idx),
  .dom_en  (dom_en),
  .dom_code(dom_code)
);

// File: tb/tb_skew_calib_top.sv
module tb_skew_calib_top;
  localparam int N = 47;
  localparam logic [7:0] CTRL = 8'hFF;
  // table rows: {cal[4:0], off[2:0], expected code[4:0]}
  localparam logic [12:0] VEC [0:8] = '{
    {5'd10, 3'd0, 5'd10}, {5'd10, 3'd3, 5'd13}, {5'd10, 3'd4, 5'd6},
    {5'd30, 3'd3, 5'd31}, {5'd2,  3'd5, 5'd0},  {5'd0,  3'd4, 5'd0},
    {5'd31, 3'd7, 5'd30}, {5'd31, 3'd3, 5'd31}, {5'd0,  3'd3, 5'd3}
  };

  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   host_addr = 0;
  logic         host_we = 0;
  logic [15:0]  host_wdata = 0;
  logic [15:0]  host_rdata;
  logic [N-2:0] pd_late;
  logic [N*5-1:0] dom_code;
  logic [N-1:0] dom_en;

  int d [N];
  int exp_cal [N];
  int exp_off [N];
  bit exp_en [N];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  skew_calib_top dut (.*);

  always_comb begin
    for (int k = 0; k < N-1; k++)
      pd_late[k] = (d[k+1] + int'(dom_code[(k+1)*5 +: 5])) > (d[k] + int'(dom_code[k*5 +: 5]));
  end

  function automatic int sat(int c, int o);
    int s = c + o;
    return (s < 0) ? 0 : (s > 31 ? 31 : s);
  endfunction

  function automatic int arr(int i, int c);
    return d[i] + sat(c, exp_off[i]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R5 watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] v);
    @(negedge clk);
    host_addr = a; host_wdata = v; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wr_dom(int i, int c, int o, bit e);
    logic [2:0] o3 = 3'(o);
    wr(8'(i), {7'd0, e, o3, 5'(c)});
    exp_cal[i] = c; exp_off[i] = o; exp_en[i] = e;
  endtask

  task automatic model_pass();
    for (int k = 0; k < N-1; k++) begin
      int c;
      if (!exp_en[0] || !exp_en[k+1]) break;
      c = exp_cal[k+1];
      if (arr(k+1, c) > arr(k, exp_cal[k])) begin
        while (c > 0 && arr(k+1, c) > arr(k, exp_cal[k])) c--;
      end else begin
        while (c < 31 && !(arr(k+1, c) > arr(k, exp_cal[k]))) c++;
      end
      exp_cal[k+1] = c;
    end
  endtask

  task automatic wait_done();
    logic [15:0] v;
    do rd(CTRL, v); while (!v[0]);
  endtask

  task automatic check_all(string req);
    logic [15:0] v;
    for (int i = 0; i < N; i++) begin
      rd(8'(i), v);
      check(req, int'(v[4:0]), exp_cal[i]);
    end
  endtask

  initial begin
    logic [15:0] v;
    for (int i = 0; i < N; i++) begin
      d[i] = (i * 5) % 11; exp_cal[i] = 16; exp_off[i] = 0; exp_en[i] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'd0, v);
    check("R1 cal", int'(v[4:0]), 16);
    check("R1 off", int'(v[7:5]), 0);
    check("R1 en", int'(v[8]), 1);
    rd(CTRL, v);
    check("R1 ctrl", int'(v[1:0]), 0);
    check("R1 dom_en", int'(dom_en == '1), 1);
    rd(8'd100, v);
    check("R2 unmapped read", int'(v), 0);

    // R2/R3 offset table on domain 3
    for (int r = 0; r < 9; r++) begin
      wr(8'd3, {7'd0, 1'b1, VEC[r][7:5], VEC[r][12:8]});
      rd(8'd3, v);
      check("R2 cal field", int'(v[4:0]), int'(VEC[r][12:8]));
      check("R2 off field", int'(v[7:5]), int'(VEC[r][7:5]));
      check("R3 code read", int'(v[13:9]), int'(VEC[r][4:0]));
      check("R3 code port", int'(dom_code[15 +: 5]), int'(VEC[r][4:0]));
    end
    wr_dom(3, 16, 0, 1);

    // R5 R6 R7 full pass with an offset on domain 7
    wr_dom(7, 16, 2, 1);
    model_pass();
    wr(CTRL, 16'h1);
    rd(CTRL, v);
    check("R5 busy after start", int'(v[1:0]), 2);
    wait_done();
    rd(CTRL, v);
    check("R5 done idle", int'(v[1:0]), 1);
    check_all("R6 pass1");
    rd(8'd0, v);
    check("R6 ref unchanged", int'(v[4:0]), 16);

    // R7 floor limit: a very late domain
    d[20] = 60;
    model_pass();
    wr(CTRL, 16'h1);
    wait_done();
    rd(8'd20, v);
    check("R7 floor", int'(v[4:0]), 0);
    check_all("R7 pass2");

    // R4 R8 disabled domain stops the chain
    wr_dom(12, exp_cal[12], 0, 0);
    check("R4 dom_en low", int'(dom_en[12]), 0);
    check("R4 dom_en other", int'(dom_en[11]), 1);
    d[5] = d[5] + 3;
    d[30] = d[30] + 4;
    model_pass();
    wr(CTRL, 16'h1);
    wait_done();
    check_all("R8 partial");
    wr_dom(12, exp_cal[12], 0, 1);

    // R9 write ignored while busy, R5 start ignored while busy
    d[2] = d[2] + 2;
    model_pass();
    wr(CTRL, 16'h1);
    wr(8'd10, {7'd0, 1'b0, 3'd3, 5'd4});
    wr(CTRL, 16'h1);
    wait_done();
    repeat (6) @(negedge clk);
    rd(CTRL, v);
    check("R5 no second pass", int'(v[1:0]), 1);
    rd(8'd10, v);
    check("R9 off kept", int'(v[7:5]), 0);
    check("R9 en kept", int'(v[8]), 1);
    check("R9 cal calibrated", int'(v[4:0]), exp_cal[10]);
    check_all("R9 pass4");

    finish_run();
  end
endmodule